// File: doc/BRIEF.md
# Sixteen-bit multi-mode timer with capture and PWM

This block is a 16-bit up-counter. Software puts it in one of three modes through a byte-wide register port. As a periodic timer or event counter, it wraps at a programmed compare value, raises a flag and toggles its output pin. As a capture unit, it free-runs and copies the running count into a capture register when a chosen capture input rises. As a PWM generator, it drives a waveform whose period and high time come from double-buffered registers.

The counter advances on a count tick. That tick comes either from a tap of a free-running divider of the main clock (eight fixed ratios) or from the rising edges of one of two external event inputs. All five asynchronous inputs (two event inputs and three capture inputs) pass through a two-flop synchronizer and a rising-edge detector. The three status flags are ORed onto a single interrupt line. Each flag is cleared by writing a one to its bit.

Top module: `tmr16_multimode`

Register map (byte address on `bus_addr`):

| Addr | Contents |
|------|----------|
| 0 | control: bits 1:0 mode (0 timer, 1 capture, 2 PWM, 3 halted), bit 2 run, bit 3 external-tick enable, bit 7 write-only counter clear |
| 1 | select: bits 2:0 divider code, bits 5:3 input select (bit 3 = event source, bits 5:4 = capture input) |
| 2/3 | compare value low/high |
| 4/5 | PWM period buffer low/high |
| 6/7 | PWM duty buffer low/high |
| 8/9 | count low / latched count high |
| 10/11 | capture low/high |
| 12 | flags: bit 0 wrap/period, bit 1 capture, bit 2 overflow |

## Requirements
- R1: After reset every register reads 0, the output pin is low and the interrupt line is low.
- R2: With external ticks disabled, divider code k = 0..7 selects a division of 1, 4, 8, 16, 64, 256, 1024, 2048. The tick fires in each cycle where the number of clock cycles since reset, modulo the division, equals division minus 1. While run is set, the counter advances once per tick.
- R3: With external ticks enabled, the counter advances once per rising edge of the event input selected by select bit 3 (0 = `ev_a`, 1 = `ev_b`). An edge is counted three clock edges after the pin rises. The unselected event input has no effect.
- R4: In timer mode, a tick while the count equals the compare value sets the count to 0, sets flag bit 0 and toggles the output pin. Any other tick adds one.
- R5: In capture mode, a rising edge on the capture input chosen by select bits 5:4 (0, 1, 2 = `cap_in[0..2]`, 3 = none) copies the count that stands in that cycle into the capture register and sets flag bit 1. Unselected capture inputs have no effect.
- R6: In capture mode, the counter free-runs. A tick at count 0xFFFF wraps it to 0 and sets flag bit 2.
- R7: In PWM mode, the pin is high while count < active duty and low otherwise. A tick at count >= active period restarts the count at 0 and sets flag bit 0.
- R8: Period and duty writes go to buffers. The buffers are copied to the active values at a PWM period restart, or on any clock edge where the block is stopped or not in PWM mode.
- R9: Reading count low returns the low byte and latches the high byte of the same count. Reading count high returns that latched byte.
- R10: Writing a one to a flag bit clears it. A flag set in the same cycle as the clear wins. The interrupt line is the OR of the three flags.
- R11: With run clear, the count holds. Writing control with bit 7 set zeroes the count, taking priority over a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | main clock |
| rst_n | input | 1 | asynchronous active-low reset |
| bus_we | input | 1 | register write strobe |
| bus_re | input | 1 | register read strobe (drives the count latch) |
| bus_addr | input | 4 | register byte address |
| bus_wdata | input | 8 | write data |
| bus_rdata | output | 8 | read data for `bus_addr` |
| ev_a | input | 1 | external event input 0 |
| ev_b | input | 1 | external event input 1 |
| cap_in | input | 3 | capture inputs |
| tmr_out | output | 1 | timer toggle or PWM waveform |
| irq | output | 1 | OR of status flags |

## Verification
The hardest state to reach is the overflow flag in capture mode. It needs a full 65,536-tick sweep of the counter, and its wrap must not be confused with the timer-mode compare wrap. The stimulus runs the divide-by-one tap in capture mode for slightly more than a full sweep. Before that, it places capture edges and an unselected capture pulse so that the capture flag and register are already in a known state when the wrap arrives. The PWM buffering is exercised by rewriting period and duty in the middle of a period, which the per-clock model then follows across the next boundary.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    localparam int CNT_W = 16;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 4;
    localparam int SEL_W = 3;
    localparam int N_CAP = 3;
    localparam int N_EV = 2;
    localparam int N_SYNC = N_EV + N_CAP;

    typedef enum logic [1:0] {
        MODE_TIMER   = 2'd0,
        MODE_CAPTURE = 2'd1,
        MODE_PWM     = 2'd2,
        MODE_HALT    = 2'd3
    } tmr_mode_e;

    localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
    localparam logic [ADDR_W-1:0] A_SEL   = 4'd1;
    localparam logic [ADDR_W-1:0] A_CMP_L = 4'd2;
    localparam logic [ADDR_W-1:0] A_CMP_H = 4'd3;
    localparam logic [ADDR_W-1:0] A_PER_L = 4'd4;
    localparam logic [ADDR_W-1:0] A_PER_H = 4'd5;
    localparam logic [ADDR_W-1:0] A_DTY_L = 4'd6;
    localparam logic [ADDR_W-1:0] A_DTY_H = 4'd7;
    localparam logic [ADDR_W-1:0] A_CNT_L = 4'd8;
    localparam logic [ADDR_W-1:0] A_CNT_H = 4'd9;
    localparam logic [ADDR_W-1:0] A_CAP_L = 4'd10;
    localparam logic [ADDR_W-1:0] A_CAP_H = 4'd11;
    localparam logic [ADDR_W-1:0] A_FLAG  = 4'd12;

    typedef struct packed {
        tmr_mode_e          mode;
        logic               run;
        logic               ext_en;
        logic [SEL_W-1:0]   div_sel;
        logic [SEL_W-1:0]   in_sel;
        logic [CNT_W-1:0]   cmp;
        logic [CNT_W-1:0]   per_buf;
        logic [CNT_W-1:0]   duty_buf;
        logic [CNT_W-1:0]   per;
        logic [CNT_W-1:0]   duty;
        logic [CNT_W-1:0]   cnt;
        logic [CNT_W-1:0]   cap;
        logic [BYTE_W-1:0]  hi_latch;
        logic [2:0]         flags;
        logic               tog;
    } tmr_state_t;

endpackage

// File: rtl/tmr16_prescaler.sv
module tmr16_prescaler #(
    parameter int PRE_W = 11,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int N_TAPS = 1 << SEL_W;

    function automatic int tap_shift(input int k);
        case (k)
            0:       return 0;
            1:       return 2;
            2:       return 3;
            3:       return 4;
            4:       return 6;
            5:       return 8;
            6:       return 10;
            default: return 11;
        endcase
    endfunction

    logic [PRE_W-1:0]  pcnt_d, pcnt_q;
    logic [N_TAPS-1:0] tap_hit;

    for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
        localparam int SH = (tap_shift(g) > PRE_W) ? PRE_W : tap_shift(g);
        localparam logic [PRE_W-1:0] MASK = PRE_W'((64'd1 << SH) - 64'd1);
        assign tap_hit[g] = ((pcnt_q & MASK) == MASK);
    end

    always_comb begin
        pcnt_d = pcnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pcnt_q <= '0;
        else        pcnt_q <= pcnt_d;
    end

    assign tick = tap_hit[sel];

    // R2
    div1_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0) |-> tick);

endmodule

// File: rtl/tmr16_edge_sync.sv
module tmr16_edge_sync #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] rise
);
    logic [N-1:0] s1_d, s1_q, s2_d, s2_q, s3_d, s3_q;

    always_comb begin
        s1_d = din;
        s2_d = s1_q;
        s3_d = s2_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
            s3_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
            s3_q <= s3_d;
        end
    end

    assign rise = s2_q & ~s3_q;

    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> ((rise & $past(rise)) == '0));

endmodule

// File: rtl/tmr16_multimode.sv
module tmr16_multimode
    import tmr16_pkg::*;
#(
    parameter int PRE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              ev_a,
    input  logic              ev_b,
    input  logic [N_CAP-1:0]  cap_in,
    output logic              tmr_out,
    output logic              irq
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    tmr_state_t       st_d, st_q;
    logic             pre_tick;
    logic [N_SYNC-1:0] rise;
    logic             ext_rise;
    logic             cap_hit;
    logic             count_tick;
    logic             clr_cnt;

    tmr16_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (st_q.div_sel),
        .tick  (pre_tick)
    );

    tmr16_edge_sync #(.N(N_SYNC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({cap_in, ev_b, ev_a}),
        .rise  (rise)
    );

    always_comb begin
        ext_rise = st_q.in_sel[0] ? rise[1] : rise[0];
        case (st_q.in_sel[2:1])
            2'd0:    cap_hit = rise[N_EV];
            2'd1:    cap_hit = rise[N_EV+1];
            2'd2:    cap_hit = rise[N_EV+2];
            default: cap_hit = 1'b0;
        endcase
        count_tick = st_q.run & (st_q.ext_en ? ext_rise : pre_tick);
    end

    always_comb begin
        st_d    = st_q;
        clr_cnt = 1'b0;

        if (bus_we) begin
            case (bus_addr)
                A_CTRL: begin
                    st_d.mode   = tmr_mode_e'(bus_wdata[1:0]);
                    st_d.run    = bus_wdata[2];
                    st_d.ext_en = bus_wdata[3];
                    clr_cnt     = bus_wdata[7];
                end
                A_SEL: begin
                    st_d.div_sel = bus_wdata[2:0];
                    st_d.in_sel  = bus_wdata[5:3];
                end
                A_CMP_L: st_d.cmp[7:0]       = bus_wdata;
                A_CMP_H: st_d.cmp[15:8]      = bus_wdata;
                A_PER_L: st_d.per_buf[7:0]   = bus_wdata;
                A_PER_H: st_d.per_buf[15:8]  = bus_wdata;
                A_DTY_L: st_d.duty_buf[7:0]  = bus_wdata;
                A_DTY_H: st_d.duty_buf[15:8] = bus_wdata;
                A_FLAG:  st_d.flags = st_q.flags & ~bus_wdata[2:0];
                default: ;
            endcase
        end

        if (bus_re && bus_addr == A_CNT_L) begin
            st_d.hi_latch = st_q.cnt[15:8];
        end

        case (st_q.mode)
            MODE_TIMER: begin
                if (count_tick) begin
                    if (st_q.cnt == st_q.cmp) begin
                        st_d.cnt      = '0;
                        st_d.flags[0] = 1'b1;
                        st_d.tog      = ~st_q.tog;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            MODE_CAPTURE: begin
                if (count_tick) begin
                    st_d.cnt = st_q.cnt + 1'b1;
                    if (st_q.cnt == CNT_MAX) st_d.flags[2] = 1'b1;
                end
                if (cap_hit) begin
                    st_d.cap      = st_q.cnt;
                    st_d.flags[1] = 1'b1;
                end
            end
            MODE_PWM: begin
                if (count_tick) begin
                    if (st_q.cnt >= st_q.per) begin
                        st_d.cnt      = '0;
                        st_d.flags[0] = 1'b1;
                        st_d.per      = st_q.per_buf;
                        st_d.duty     = st_q.duty_buf;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            default: ;
        endcase

        if (!st_q.run || st_q.mode != MODE_PWM) begin
            st_d.per  = st_q.per_buf;
            st_d.duty = st_q.duty_buf;
        end

        if (clr_cnt) st_d.cnt = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = {4'b0000, st_q.ext_en, st_q.run, st_q.mode};
            A_SEL:   bus_rdata = {2'b00, st_q.in_sel, st_q.div_sel};
            A_CMP_L: bus_rdata = st_q.cmp[7:0];
            A_CMP_H: bus_rdata = st_q.cmp[15:8];
            A_PER_L: bus_rdata = st_q.per_buf[7:0];
            A_PER_H: bus_rdata = st_q.per_buf[15:8];
            A_DTY_L: bus_rdata = st_q.duty_buf[7:0];
            A_DTY_H: bus_rdata = st_q.duty_buf[15:8];
            A_CNT_L: bus_rdata = st_q.cnt[7:0];
            A_CNT_H: bus_rdata = st_q.hi_latch;
            A_CAP_L: bus_rdata = st_q.cap[7:0];
            A_CAP_H: bus_rdata = st_q.cap[15:8];
            A_FLAG:  bus_rdata = {5'b00000, st_q.flags};
            default: bus_rdata = '0;
        endcase
    end

    always_comb begin
        case (st_q.mode)
            MODE_PWM:   tmr_out = (st_q.cnt < st_q.duty);
            MODE_TIMER: tmr_out = st_q.tog;
            default:    tmr_out = 1'b0;
        endcase
        irq = |st_q.flags;
    end

    // R11
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run && !clr_cnt) |=> (st_q.cnt == $past(st_q.cnt)));

    // R4
    match_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_TIMER && count_tick && st_q.cnt == st_q.cmp && !clr_cnt)
        |=> (st_q.cnt == '0 && st_q.flags[0]));

    // R6
    ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_CAPTURE && count_tick && st_q.cnt == CNT_MAX) |=> st_q.flags[2]);

    // R5
    cap_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_CAPTURE && cap_hit)
        |=> (st_q.cap == $past(st_q.cnt) && st_q.flags[1]));

    // R8
    pwm_buffer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && st_q.mode == MODE_PWM && !(count_tick && st_q.cnt >= st_q.per))
        |=> ($stable(st_q.duty) && $stable(st_q.per)));

endmodule

// File: tb/tb_tmr16_multimode.sv
module tb_tmr16_multimode;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       b_we = 1'b0;
    logic       b_re = 1'b0;
    logic [3:0] b_addr = 4'd0;
    logic [7:0] b_wdata = 8'd0;
    logic [7:0] b_rdata;
    logic       b_ev_a = 1'b0;
    logic       b_ev_b = 1'b0;
    logic [2:0] b_cap = 3'b000;
    logic       t_out;
    logic       t_irq;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tmr16_multimode dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (b_we),
        .bus_re    (b_re),
        .bus_addr  (b_addr),
        .bus_wdata (b_wdata),
        .bus_rdata (b_rdata),
        .ev_a      (b_ev_a),
        .ev_b      (b_ev_b),
        .cap_in    (b_cap),
        .tmr_out   (t_out),
        .irq       (t_irq)
    );

    // behavioural reference state
    logic [15:0] m_cnt, m_cmp, m_perb, m_dutyb, m_per, m_duty, m_cap;
    logic [7:0]  m_hi;
    logic [2:0]  m_flags;
    logic [1:0]  m_mode;
    logic        m_run, m_ext, m_tog;
    logic [2:0]  m_div, m_in;
    logic [4:0]  m_s1, m_s2, m_s3;
    int unsigned m_pcnt;
    int          divs [8] = '{1, 4, 8, 16, 64, 256, 1024, 2048};

    task automatic model_reset();
        m_cnt = 0; m_cmp = 0; m_perb = 0; m_dutyb = 0; m_per = 0; m_duty = 0; m_cap = 0;
        m_hi = 0; m_flags = 0; m_mode = 0; m_run = 0; m_ext = 0; m_tog = 0;
        m_div = 0; m_in = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_pcnt = 0;
    endtask

    task automatic model_step();
        logic [4:0]  rise;
        int          dv;
        bit          ptick, tick, caphit, clr;
        logic [15:0] n_cnt;
        logic [2:0]  n_flags;
        rise   = m_s2 & ~m_s3;
        dv     = divs[m_div];
        ptick  = ((m_pcnt % dv) == dv - 1);
        tick   = m_run && (m_ext ? rise[m_in[0]] : ptick);
        caphit = (m_in[2:1] == 2'd0 && rise[2]) || (m_in[2:1] == 2'd1 && rise[3]) ||
                 (m_in[2:1] == 2'd2 && rise[4]);
        clr    = b_we && b_addr == 4'd0 && b_wdata[7];
        n_cnt  = m_cnt;
        n_flags = m_flags;
        if (b_we && b_addr == 4'd12) n_flags = n_flags & ~b_wdata[2:0];
        if (b_re && b_addr == 4'd8) m_hi = m_cnt[15:8];
        if (m_mode == 2'd0 && tick) begin
            if (m_cnt == m_cmp) begin
                n_cnt = 0; n_flags[0] = 1'b1; m_tog = ~m_tog;
            end else n_cnt = m_cnt + 16'd1;
        end
        if (m_mode == 2'd1) begin
            if (tick) begin
                n_cnt = m_cnt + 16'd1;
                if (m_cnt == 16'hFFFF) n_flags[2] = 1'b1;
            end
            if (caphit) begin
                m_cap = m_cnt; n_flags[1] = 1'b1;
            end
        end
        if (m_mode == 2'd2 && tick) begin
            if (m_cnt >= m_per) begin
                n_cnt = 0; n_flags[0] = 1'b1; m_per = m_perb; m_duty = m_dutyb;
            end else n_cnt = m_cnt + 16'd1;
        end
        if (!m_run || m_mode != 2'd2) begin
            m_per = m_perb; m_duty = m_dutyb;
        end
        if (clr) n_cnt = 0;
        if (b_we) begin
            case (b_addr)
                4'd0: begin m_mode = b_wdata[1:0]; m_run = b_wdata[2]; m_ext = b_wdata[3]; end
                4'd1: begin m_div = b_wdata[2:0]; m_in = b_wdata[5:3]; end
                4'd2: m_cmp[7:0]    = b_wdata;
                4'd3: m_cmp[15:8]   = b_wdata;
                4'd4: m_perb[7:0]   = b_wdata;
                4'd5: m_perb[15:8]  = b_wdata;
                4'd6: m_dutyb[7:0]  = b_wdata;
                4'd7: m_dutyb[15:8] = b_wdata;
                default: ;
            endcase
        end
        m_cnt = n_cnt;
        m_flags = n_flags;
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = {b_cap, b_ev_b, b_ev_a};
        m_pcnt++;
    endtask

    function automatic logic [7:0] m_read(input logic [3:0] a);
        case (a)
            4'd0:  return {4'b0, m_ext, m_run, m_mode};
            4'd1:  return {2'b0, m_in, m_div};
            4'd2:  return m_cmp[7:0];
            4'd3:  return m_cmp[15:8];
            4'd4:  return m_perb[7:0];
            4'd5:  return m_perb[15:8];
            4'd6:  return m_dutyb[7:0];
            4'd7:  return m_dutyb[15:8];
            4'd8:  return m_cnt[7:0];
            4'd9:  return m_hi;
            4'd10: return m_cap[7:0];
            4'd11: return m_cap[15:8];
            4'd12: return {5'b0, m_flags};
            default: return 8'd0;
        endcase
    endfunction

    function automatic logic m_outpin();
        if (m_mode == 2'd2) return (m_cnt < m_duty);
        if (m_mode == 2'd0) return m_tog;
        return 1'b0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) model_reset();
        else        model_step();
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // per-clock comparison of the pin and interrupt line
    always @(negedge clk) begin
        if (rst_n && cmp_en) begin
            chk((m_mode == 2'd2) ? "R7 pin" : "R4 pin", {15'd0, t_out}, {15'd0, m_outpin()});
            chk("R10 irq", {15'd0, t_irq}, {15'd0, |m_flags});
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        b_we = 1'b1; b_addr = a; b_wdata = d;
        @(negedge clk);
        b_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input string req);
        @(negedge clk);
        b_re = 1'b1; b_addr = a;
        #1;
        chk(req, {8'd0, b_rdata}, {8'd0, m_read(a)});
        @(negedge clk);
        b_re = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: b_ev_a = 1'b1;
            1: b_ev_b = 1'b1;
            default: b_cap[which-2] = 1'b1;
        endcase
        idle(2);
        b_ev_a = 1'b0; b_ev_b = 1'b0; b_cap = 3'b000;
        idle(2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1'b1;

        // R1 reset state
        chk("R1 pin", {15'd0, t_out}, 16'd0);
        chk("R1 irq", {15'd0, t_irq}, 16'd0);
        for (int a = 0; a < 13; a++) rd(a[3:0], "R1 reg");

        // R4 timer wrap at compare, divide by 1
        wr(4'd2, 8'd5); wr(4'd3, 8'd0); wr(4'd1, 8'h00);
        wr(4'd0, 8'h84);
        idle(40);
        rd(4'd12, "R4 flag");
        // R10 write-one-to-clear
        wr(4'd12, 8'h01);
        rd(4'd12, "R10 clear");

        // R2 divider taps
        wr(4'd1, 8'h02); wr(4'd2, 8'd3);
        idle(100);
        rd(4'd8, "R2 div8");
        wr(4'd1, 8'h04); wr(4'd2, 8'd200);
        idle(700);
        rd(4'd8, "R2 div64");
        wr(4'd1, 8'h07); wr(4'd2, 8'd1);
        idle(5000);
        rd(4'd8, "R2 div2048");
        rd(4'd12, "R2 flag");

        // R11 hold and clear
        wr(4'd0, 8'h00);
        rd(4'd8, "R11 held");
        idle(30);
        rd(4'd8, "R11 still held");
        wr(4'd0, 8'h80);
        rd(4'd8, "R11 cleared");

        // R9 coherent 16-bit read across a byte carry
        wr(4'd1, 8'h00); wr(4'd2, 8'hFF); wr(4'd3, 8'hFF);
        wr(4'd0, 8'h84);
        idle(240);
        rd(4'd8, "R9 low");
        idle(30);
        rd(4'd9, "R9 latched high");

        // R3 external event counting on ev_b, ev_a ignored
        wr(4'd1, 8'h08);
        wr(4'd0, 8'h8C);
        for (int i = 0; i < 4; i++) pulse(0);
        rd(4'd8, "R3 unselected ignored");
        for (int i = 0; i < 3; i++) pulse(1);
        rd(4'd8, "R3 count ev_b");
        wr(4'd1, 8'h00);
        for (int i = 0; i < 2; i++) pulse(0);
        pulse(1);
        rd(4'd8, "R3 count ev_a");

        // R5 capture on cap_in[1]
        wr(4'd12, 8'h07);
        wr(4'd1, 8'h10);
        wr(4'd0, 8'h85);
        idle(37);
        pulse(3);
        rd(4'd10, "R5 cap low");
        rd(4'd11, "R5 cap high");
        rd(4'd12, "R5 flag");
        pulse(2);
        pulse(4);
        rd(4'd10, "R5 unselected ignored");
        wr(4'd1, 8'h30);
        pulse(3);
        rd(4'd10, "R5 none selected");
        wr(4'd1, 8'h10);
        pulse(3);
        rd(4'd10, "R5 second capture");

        // R6 overflow after a full sweep
        wr(4'd12, 8'h07);
        rd(4'd12, "R10 all cleared");
        idle(65600);
        rd(4'd12, "R6 overflow flag");
        rd(4'd8, "R6 wrapped count");

        // R7 PWM waveform, R8 buffered reload
        wr(4'd12, 8'h07);
        wr(4'd4, 8'd9); wr(4'd5, 8'd0);
        wr(4'd6, 8'd3); wr(4'd7, 8'd0);
        wr(4'd0, 8'h86);
        idle(35);
        wr(4'd6, 8'd7);
        wr(4'd4, 8'd4);
        rd(4'd6, "R8 duty buffer");
        idle(30);
        wr(4'd6, 8'd0);
        idle(20);
        wr(4'd6, 8'd20);
        idle(20);
        rd(4'd12, "R7 period flag");
        wr(4'd4, 8'd0);
        idle(10);
        wr(4'd0, 8'h02);
        wr(4'd6, 8'd1);
        idle(5);
        wr(4'd0, 8'h86);
        idle(20);
        rd(4'd8, "R7 count");

        cmp_en = 1'b0;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule